// File: doc/BRIEF.md
# Counter-Predicated Multi-Vector Select Unit

This block merges two groups of vector registers element by element. Each group holds two or four registers, and each register is `VLEN` bits wide. A single compact predicate word controls the merge. The word holds an active-element count and an invert flag, and it is expanded into a mask that runs across the whole group in register order. Each active element of the destination group comes from the first source group. Each inactive element comes from the second source group. The element size is chosen per operation from 8, 16, 32 or 64 bits.

The unit sits between operand read and writeback in a vector pipeline. It has no sequencing of its own. All destination registers of an operation are formed in the same cycle and captured together in one output register. A writeback of the group therefore never exposes a partial result. It also never depends on the order in which registers that overlap the sources are written.

Top module: `msel_unit`

## Requirements
- R1: `size_code` selects the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. All bytes of one element are always taken from the same source.
- R2: `quad` = 1 selects a four-register group and `quad` = 0 selects a two-register group. Register r of every group bus occupies bits [r*VLEN +: VLEN].
- R3: An active element is copied from `src_a`. An inactive element is copied from `src_b`.
- R4: Element e of register r has flat mask index r*(VLEN/esize)+e, so the mask continues from one register into the next.
- R5: `pred_cnt[14:0]` is the count K and `pred_cnt[15]` is the invert flag. With the flag clear, flat elements with index below K are active. With the flag set, elements with index K and above are active.
- R6: K is saturated at the number of elements in the group. A K at or above that number makes every element active with the flag clear, and makes none active with the flag set.
- R7: In two-register mode, destination registers 2 and 3 read as zero.
- R8: `dst_q` shows the result for the inputs sampled at the previous rising clock edge. All destination registers update at that one edge.
- R9: While `rst_n` is low, `dst_q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_code | input | 2 | Element width code |
| quad | input | 1 | 1 selects a four-register group, 0 selects a two-register group |
| pred_cnt | input | 16 | Bit 15 is the invert flag, bits 14:0 are the active count K |
| src_a | input | 4*VLEN | First source group, selected for active elements |
| src_b | input | 4*VLEN | Second source group, selected for inactive elements |
| dst_q | output | 4*VLEN | Registered destination group |

## Verification
The bench sweeps every element size, both group sizes and both invert settings. For each combination it runs K from zero to a few counts past the group's element total, so every place the boundary can fall is covered. This includes boundaries inside a register and boundaries on a register edge. A design that resets the mask index at each register would corrupt the second and later registers. A design that tests only the low byte of a wide element, or that counts bytes instead of elements, would split elements or shift the boundary. Large random values of K catch a missing saturation or a compare that wraps. Two-register vectors catch stale data leaking into the unused upper registers.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_DWORD = 2'd3
    } esz_e;

    typedef enum logic {
        GRP_PAIR = 1'b0,
        GRP_QUAD = 1'b1
    } grp_e;

    localparam int unsigned CNT_W = 15;

endpackage

// File: rtl/msel_mask_gen.sv
module msel_mask_gen
    import msel_pkg::*;
#(
    parameter int unsigned PL   = 16,
    parameter int unsigned NREG = 4
) (
    input  esz_e                   esz,
    input  grp_e                   grp,
    input  logic [CNT_W-1:0]       cnt,
    input  logic                   inv,
    output logic [PL*NREG-1:0]     take_a,
    output logic [PL*NREG-1:0]     in_grp
);
    localparam int unsigned TB    = PL * NREG;
    localparam int unsigned PAIRB = PL * 2;

    logic [CNT_W-1:0] grp_bytes;
    logic [CNT_W-1:0] n_elem;
    logic [CNT_W-1:0] k_sat;

    always_comb begin
        grp_bytes = (grp == GRP_QUAD) ? CNT_W'(TB) : CNT_W'(PAIRB);
        n_elem    = grp_bytes >> esz;
        k_sat     = (cnt > n_elem) ? n_elem : cnt;
    end

    for (genvar g = 0; g < TB; g++) begin : g_byte
        localparam logic [CNT_W-1:0] BIDX = CNT_W'(g);
        logic [CNT_W-1:0] elem_idx;
        assign elem_idx  = BIDX >> esz;
        assign take_a[g] = (elem_idx < k_sat) ^ inv;
        assign in_grp[g] = (grp == GRP_QUAD) || (g < PAIRB);
    end

endmodule

// File: rtl/msel_byte_mux.sv
module msel_byte_mux (
    input  logic [7:0] a_byte,
    input  logic [7:0] b_byte,
    input  logic       pick_a,
    input  logic       live,
    output logic [7:0] y_byte
);
    always_comb begin
        if (!live)       y_byte = 8'h00;
        else if (pick_a) y_byte = a_byte;
        else             y_byte = b_byte;
    end
endmodule

// File: rtl/msel_unit.sv
module msel_unit
    import msel_pkg::*;
#(
    parameter int unsigned VLEN = 128,
    parameter int unsigned NREG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           size_code,
    input  logic                 quad,
    input  logic [15:0]          pred_cnt,
    input  logic [NREG*VLEN-1:0] src_a,
    input  logic [NREG*VLEN-1:0] src_b,
    output logic [NREG*VLEN-1:0] dst_q
);
    localparam int unsigned PL = VLEN / 8;
    localparam int unsigned TB = PL * NREG;
    localparam int unsigned BW = NREG * VLEN;

    esz_e            esz;
    grp_e            grp;
    logic [TB-1:0]   take_a;
    logic [TB-1:0]   in_grp;
    logic [BW-1:0]   merged;

    assign esz = esz_e'(size_code);
    assign grp = grp_e'(quad);

    msel_mask_gen #(.PL(PL), .NREG(NREG)) u_mask (
        .esz    (esz),
        .grp    (grp),
        .cnt    (pred_cnt[CNT_W-1:0]),
        .inv    (pred_cnt[15]),
        .take_a (take_a),
        .in_grp (in_grp)
    );

    for (genvar g = 0; g < TB; g++) begin : g_lane
        msel_byte_mux u_mux (
            .a_byte (src_a[g*8 +: 8]),
            .b_byte (src_b[g*8 +: 8]),
            .pick_a (take_a[g]),
            .live   (in_grp[g]),
            .y_byte (merged[g*8 +: 8])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dst_q <= '0;
        else        dst_q <= merged;
    end

endmodule

// File: rtl/msel_unit_chk.sv
module msel_unit_chk #(
    parameter int unsigned VLEN = 128,
    parameter int unsigned NREG = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           size_code,
    input logic                 quad,
    input logic [15:0]          pred_cnt,
    input logic [NREG*VLEN-1:0] src_a,
    input logic [NREG*VLEN-1:0] src_b,
    input logic [NREG*VLEN-1:0] dst_q
);
    localparam int unsigned BW = NREG * VLEN;
    localparam int unsigned TB = BW / 8;

    // R9: reset clears the whole destination group
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> dst_q == '0);

    // R7: unused upper registers read zero in two-register mode
    p_pair_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !quad |=> dst_q[BW-1:BW/2] == '0);

    // R5 R8: count zero with the flag clear copies the second source
    p_empty_takes_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && !pred_cnt[15] && pred_cnt[14:0] == 15'd0) |=> dst_q == $past(src_b));

    // R5: count zero with the flag set copies the first source
    p_inv_empty_all_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && pred_cnt[15] && pred_cnt[14:0] == 15'd0) |=> dst_q == $past(src_a));

    // R6: an oversized count saturates to all active
    p_saturate_all_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && !pred_cnt[15] && pred_cnt[14:0] >= 15'(TB)) |=> dst_q == $past(src_a));

    // R4: with byte elements and count one, only flat element 0 is active
    p_first_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && size_code == 2'd0 && pred_cnt == 16'd1)
        |=> (dst_q[7:0] == $past(src_a[7:0])) && (dst_q[BW-1:8] == $past(src_b[BW-1:8])));

endmodule

bind msel_unit msel_unit_chk #(.VLEN(VLEN), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_code (size_code),
    .quad      (quad),
    .pred_cnt  (pred_cnt),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_q     (dst_q)
);

// File: tb/msel_unit_test.sv
`timescale 1ns/1ps
module msel_unit_test;
    localparam int VLEN = 128;
    localparam int NREG = 4;
    localparam int BW   = NREG * VLEN;
    localparam int PL   = VLEN / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    size_code = 2'd0;
    logic          quad = 1'b0;
    logic [15:0]   pred_cnt = 16'd0;
    logic [BW-1:0] src_a = '0;
    logic [BW-1:0] src_b = '0;
    logic [BW-1:0] dst_q;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    msel_unit #(.VLEN(VLEN), .NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .size_code(size_code), .quad(quad),
        .pred_cnt(pred_cnt), .src_a(src_a), .src_b(src_b), .dst_q(dst_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Reference: walk registers and elements, decide per element, copy its bytes.
    function automatic logic [BW-1:0] ref_sel(input logic [1:0] sz, input logic q,
                                              input logic [15:0] pc,
                                              input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] r;
        int ebytes, epr, nreg, total, k, flat;
        bit act;
        r      = '0;
        ebytes = 1 << sz;
        epr    = PL / ebytes;
        nreg   = q ? 4 : 2;
        total  = epr * nreg;
        k      = int'(pc[14:0]);
        if (k > total) k = total;
        for (int rg = 0; rg < nreg; rg++) begin
            for (int e = 0; e < epr; e++) begin
                flat = rg * epr + e;
                act  = pc[15] ? (flat >= k) : (flat < k);
                for (int by = 0; by < ebytes; by++) begin
                    int pos;
                    pos = (rg * PL + e * ebytes + by) * 8;
                    r[pos +: 8] = act ? a[pos +: 8] : b[pos +: 8];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] rnd_bus();
        logic [BW-1:0] v;
        for (int i = 0; i < BW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic apply(input logic [1:0] sz, input logic q, input logic [15:0] pc,
                         input string tag);
        logic [BW-1:0] exp;
        @(negedge clk);
        size_code = sz; quad = q; pred_cnt = pc;
        src_a = rnd_bus(); src_b = rnd_bus();
        exp = ref_sel(sz, q, pc, src_a, src_b);
        @(negedge clk);
        vectors++;
        if (dst_q !== exp) begin
            miscompares++;
            $display("FAIL %s size=%0d quad=%0b pc=%h: actual %h expected %h",
                     tag, sz, q, pc, dst_q, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        src_a = rnd_bus(); src_b = rnd_bus(); pred_cnt = 16'h0005; quad = 1'b1;
        repeat (3) @(negedge clk);
        vectors++;
        if (dst_q !== '0) begin
            miscompares++;
            $display("FAIL R9 reset: actual %h expected 0", dst_q);
        end
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R8: sweep every boundary position
        for (int sz = 0; sz < 4; sz++) begin
            for (int q = 0; q < 2; q++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    int total;
                    total = (PL >> sz) * (q ? 4 : 2);
                    for (int k = 0; k <= total + 3; k++) begin
                        apply(2'(sz), 1'(q), {1'(inv), 15'(k)},
                              k >= total ? "R6 R5 R3" : (q ? "R1 R2 R3 R4 R5 R8" : "R7 R2 R4 R5"));
                    end
                end
            end
        end

        // R6: large counts, including the top of the field
        apply(2'd0, 1'b1, 16'h7FFF, "R6");
        apply(2'd3, 1'b0, 16'hFFFF, "R6 R7");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] pc;
            pc = 16'($urandom);
            if (i % 2 == 0) pc[14:0] = 15'($urandom_range(0, 70));
            apply(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), pc, "R1 R3 R5 R8");
        end

        // R9: reset in mid-run clears the output again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        vectors++;
        if (dst_q !== '0) begin
            miscompares++;
            $display("FAIL R9 reassert: actual %h expected 0", dst_q);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule